// File: doc/BRIEF.md
# Per-Slave Register Write Access Guard

This guard sits in front of one bus slave (a peripheral or a memory) and decides for each request whether a write from a given bus master reaches the slave. A per-master enable register holds one bit per master ID. A write from a master whose bit is clear is discarded. Reads are never filtered.

A subrange of the slave's address space holds safety-related registers. A write to that range also needs the unlock window from the safety watchdog to be open at the time of the write. The guard's own enable register and its lock bit follow the same rule. They can be changed only by an enabled master while the window is open. Because the watchdog slave has its own guard, a master without watchdog access cannot open the window, so it cannot widen its own rights. Once initialization is done, a one-shot lock bit freezes the guard's configuration until the next reset.

The variant parameter `SAFETY_ONLY` marks a slave as safety-critical, such as an output port. On such a slave only the master numbered `SAFETY_MASTER` can ever be granted writes, whatever the enable register holds. Every rejected write gives a one-cycle violation pulse and records the offending master ID.

Top module: `wr_access_guard`

## Requirements
- R1: A read request (`req_write_i`=0) is always forwarded on `slv_rd_o` in the same cycle. It never raises `violation_o`.
- R2: A write to an ordinary slave address (outside the safety range and not 0xF0 or 0xF4) is forwarded on `slv_wr_o` in the same cycle exactly when bit `req_master_i` of the enable register is 1.
- R3: A write to the safety range 0x80..0x8F is forwarded only when the master is enabled and `unlock_i` is 1. The addresses 0x7F and 0x90 are ordinary addresses.
- R4: After reset the enable register reads all ones (`master_en_o`=4'b1111) and `cfg_locked_o` is 0.
- R5: A write to address 0xF0 loads `req_wdata_i` into the enable register. This is visible on `master_en_o` after the next clock edge, and happens only when the master is enabled, `unlock_i` is 1 and the guard is not locked. Otherwise the register keeps its value.
- R6: A write to address 0xF4 with `req_wdata_i[0]`=1 sets the lock under the same conditions as R5. From then on, writes to 0xF0 and 0xF4 are rejected, and `master_en_o` and `cfg_locked_o` stay unchanged until reset.
- R7: A rejected write is not forwarded. In the cycle after it, `violation_o` is high for one cycle and `viol_master_o` holds the offending master ID.
- R8: With `SAFETY_ONLY`=1, `slv_wr_o` can be asserted only for master `SAFETY_MASTER`. Writes from any other master are rejected even when their enable bit is 1.
- R9: `viol_master_o` keeps the last offending ID until the next violation. Accepted writes and reads do not change it.
- R10: Writes to the guard's own addresses 0xF0 and 0xF4 are never forwarded to the slave on `slv_wr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_master_i | input | MID_W (2) | ID of the requesting master |
| req_addr_i | input | ADDR_W (8) | Register address within the slave |
| req_wdata_i | input | NUM_M (4) | Write data, used by the guard's own registers |
| unlock_i | input | 1 | Unlock window from the safety watchdog |
| slv_wr_o | output | 1 | Write forwarded to the slave |
| slv_rd_o | output | 1 | Read forwarded to the slave |
| violation_o | output | 1 | One-cycle pulse after a rejected write |
| viol_master_o | output | MID_W (2) | ID of the last rejected master |
| master_en_o | output | NUM_M (4) | Current per-master enable register |
| cfg_locked_o | output | 1 | Configuration lock state |

## Verification
Some rules are checked by assertions on every cycle. A violation pulse must follow a write that was not forwarded, and a read can never cause one. A forwarded safety-range write must coincide with an open unlock window. Once the lock is set, it and the enable register must stay frozen. On the safety-only variant, forwarded writes must come from the safety master. Other behaviour only shows up in the bench's scenarios: the exact range boundaries, the reset values, that a rejected configuration write leaves the register untouched, that a reset clears the lock, and that the recorded ID survives accepted traffic.

// File: rtl/wr_guard_pkg.sv
package wr_guard_pkg;
  typedef enum logic [1:0] {
    TGT_PLAIN = 2'd0,
    TGT_SAFE  = 2'd1,
    TGT_CFG   = 2'd2,
    TGT_LOCK  = 2'd3
  } tgt_e;
endpackage

// File: rtl/wr_guard_decode.sv
module wr_guard_decode import wr_guard_pkg::*; #(
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR  = 8'hF0,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 8'hF4,
  parameter logic [ADDR_W-1:0] SAFE_LO   = 8'h80,
  parameter logic [ADDR_W-1:0] SAFE_HI   = 8'h8F
) (
  input  logic [ADDR_W-1:0] addr_i,
  output tgt_e              tgt_o
);
  always_comb begin
    if (addr_i == CFG_ADDR)                         tgt_o = TGT_CFG;
    else if (addr_i == LOCK_ADDR)                   tgt_o = TGT_LOCK;
    else if (addr_i >= SAFE_LO && addr_i <= SAFE_HI) tgt_o = TGT_SAFE;
    else                                            tgt_o = TGT_PLAIN;
  end
endmodule

// File: rtl/wr_guard_perm.sv
module wr_guard_perm #(
  parameter int unsigned NUM_M = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_we_i,
  input  logic             lock_we_i,
  input  logic [NUM_M-1:0] wdata_i,
  output logic [NUM_M-1:0] en_o,
  output logic             locked_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= '1;
      locked_o <= 1'b0;
    end else begin
      if (en_we_i && !locked_o)  en_o     <= wdata_i;
      if (lock_we_i && !locked_o) locked_o <= 1'b1;
    end
  end

  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> locked_o);
  assert_en_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_o |=> $stable(en_o));
endmodule

// File: rtl/wr_guard_viol.sv
module wr_guard_viol #(
  parameter int unsigned MID_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reject_i,
  input  logic [MID_W-1:0] mid_i,
  output logic             viol_o,
  output logic [MID_W-1:0] viol_mid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o     <= 1'b0;
      viol_mid_o <= '0;
    end else begin
      viol_o <= reject_i;
      if (reject_i) viol_mid_o <= mid_i;
    end
  end

  assert_id_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reject_i |=> $stable(viol_mid_o));
endmodule

// File: rtl/wr_access_guard.sv
module wr_access_guard import wr_guard_pkg::*; #(
  parameter int unsigned NUM_M         = 4,
  parameter int unsigned ADDR_W        = 8,
  parameter bit          SAFETY_ONLY   = 1'b0,
  parameter int unsigned SAFETY_MASTER = 0,
  localparam int unsigned MID_W        = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [MID_W-1:0]  req_master_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NUM_M-1:0]  req_wdata_i,
  input  logic              unlock_i,
  output logic              slv_wr_o,
  output logic              slv_rd_o,
  output logic              violation_o,
  output logic [MID_W-1:0]  viol_master_o,
  output logic [NUM_M-1:0]  master_en_o,
  output logic              cfg_locked_o
);
  tgt_e             tgt;
  logic [NUM_M-1:0] grant_mask;
  logic             granted, is_wr, ok, accept, reject;
  logic             en_we, lock_we;

  wr_guard_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i(req_addr_i),
    .tgt_o (tgt)
  );

  generate
    if (SAFETY_ONLY) begin : g_safety_slave
      localparam logic [NUM_M-1:0] ONLY_MASK = NUM_M'(1) << SAFETY_MASTER;
      assign grant_mask = master_en_o & ONLY_MASK;
      assert_safety_only_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slv_wr_o |-> (req_master_i == MID_W'(SAFETY_MASTER)));
    end else begin : g_plain_slave
      assign grant_mask = master_en_o;
    end
  endgenerate

  assign granted = grant_mask[req_master_i];
  assign is_wr   = req_valid_i && req_write_i;

  always_comb begin
    unique case (tgt)
      TGT_PLAIN: ok = granted;
      TGT_SAFE:  ok = granted && unlock_i;
      default:   ok = granted && unlock_i && !cfg_locked_o;
    endcase
  end

  assign accept   = is_wr && ok;
  assign reject   = is_wr && !ok;
  assign slv_wr_o = accept && (tgt == TGT_PLAIN || tgt == TGT_SAFE);
  assign slv_rd_o = req_valid_i && !req_write_i;
  assign en_we    = accept && (tgt == TGT_CFG);
  assign lock_we  = accept && (tgt == TGT_LOCK) && req_wdata_i[0];

  wr_guard_perm #(.NUM_M(NUM_M)) u_perm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_we_i  (en_we),
    .lock_we_i(lock_we),
    .wdata_i  (req_wdata_i),
    .en_o     (master_en_o),
    .locked_o (cfg_locked_o)
  );

  wr_guard_viol #(.MID_W(MID_W)) u_viol (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .reject_i  (reject),
    .mid_i     (req_master_i),
    .viol_o    (violation_o),
    .viol_mid_o(viol_master_o)
  );

  assert_read_no_viol_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> !violation_o);
  assert_viol_after_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation_o |-> ($past(req_valid_i && req_write_i) && !$past(slv_wr_o)));
  assert_safe_needs_unlock_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slv_wr_o && tgt == TGT_SAFE) |-> unlock_i);
  assert_cfg_not_forwarded_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt == TGT_CFG || tgt == TGT_LOCK) |-> !slv_wr_o);
endmodule

// File: tb/wr_access_guard_tb.sv
module wr_access_guard_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0, write = 1'b0, unlock = 1'b0;
  logic [1:0] mid = '0;
  logic [7:0] addr = '0;
  logic [3:0] wdata = '0;
  logic       s_wr, s_rd, viol, locked;
  logic [1:0] vmid;
  logic [3:0] men;
  logic       q_wr, q_rd, q_viol, q_locked;
  logic [1:0] q_vmid;
  logic [3:0] q_men;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  wr_access_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_master_i(mid), .req_addr_i(addr), .req_wdata_i(wdata), .unlock_i(unlock),
    .slv_wr_o(s_wr), .slv_rd_o(s_rd), .violation_o(viol), .viol_master_o(vmid),
    .master_en_o(men), .cfg_locked_o(locked));

  wr_access_guard #(.SAFETY_ONLY(1'b1), .SAFETY_MASTER(2)) u_safe (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_master_i(mid), .req_addr_i(addr), .req_wdata_i(wdata), .unlock_i(unlock),
    .slv_wr_o(q_wr), .slv_rd_o(q_rd), .violation_o(q_viol), .viol_master_o(q_vmid),
    .master_en_o(q_men), .cfg_locked_o(q_locked));

  // {wr, mid[1:0], addr[7:0], unlock, exp_wr, exp_rd, exp_viol}; enable = 4'b0101
  localparam int NV = 11;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h10, 1'b0, 3'b100},
    {1'b1, 2'd1, 8'h10, 1'b0, 3'b001},
    {1'b0, 2'd1, 8'h10, 1'b0, 3'b010},
    {1'b1, 2'd2, 8'h85, 1'b0, 3'b001},
    {1'b1, 2'd2, 8'h85, 1'b1, 3'b100},
    {1'b1, 2'd3, 8'h85, 1'b1, 3'b001},
    {1'b0, 2'd3, 8'h85, 1'b0, 3'b010},
    {1'b1, 2'd0, 8'hF0, 1'b0, 3'b001},
    {1'b1, 2'd2, 8'h8F, 1'b1, 3'b100},
    {1'b1, 2'd0, 8'h90, 1'b0, 3'b100},
    {1'b1, 2'd2, 8'h7F, 1'b0, 3'b100}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic w, input logic [1:0] m, input logic [7:0] a,
                       input logic u, input logic [3:0] d);
    @(negedge clk);
    valid = 1'b1; write = w; mid = m; addr = a; unlock = u; wdata = d;
    #1;
  endtask

  task automatic close_cycle;
    @(posedge clk); #1;
    valid = 1'b0; write = 1'b0; unlock = 1'b0; wdata = '0;
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(men == 4'b1111, "R4 enable reset", men, 15);
    chk(locked == 1'b0, "R4 lock reset", locked, 0);
    chk(viol == 1'b0, "R4 violation reset", viol, 0);
    rst_n = 1'b1;

    // R5: enable masters 0 and 2
    drive(1'b1, 2'd0, 8'hF0, 1'b1, 4'b0101);
    chk(s_wr == 1'b0, "R10 cfg write not forwarded", s_wr, 0);
    close_cycle();
    chk(men == 4'b0101, "R5 cfg write applied", men, 5);
    chk(viol == 1'b0, "R5 no violation on accepted cfg", viol, 0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][14], VEC[i][13:12], VEC[i][11:4], VEC[i][3], 4'b0000);
      chk(s_wr == VEC[i][2], "R2/R3 slv_wr", s_wr, VEC[i][2]);
      chk(s_rd == VEC[i][1], "R1 slv_rd", s_rd, VEC[i][1]);
      close_cycle();
      chk(viol == VEC[i][0], "R7 violation", viol, VEC[i][0]);
      if (VEC[i][0]) chk(vmid == VEC[i][13:12], "R7 offender id", vmid, VEC[i][13:12]);
    end
    chk(men == 4'b0101, "R5 cfg without unlock ignored", men, 5);

    // R7 one-cycle pulse
    @(negedge clk); #1;
    chk(viol == 1'b0, "R7 pulse width", viol, 0);

    // R5 disabled master cannot reconfigure
    drive(1'b1, 2'd1, 8'hF0, 1'b1, 4'b1111);
    close_cycle();
    chk(men == 4'b0101, "R5 disabled master cfg ignored", men, 5);
    chk(viol == 1'b1 && vmid == 2'd1, "R7 disabled cfg violation", vmid, 1);

    // R9 id held across accepted write and read
    drive(1'b1, 2'd0, 8'h20, 1'b0, 4'b0);
    close_cycle();
    drive(1'b0, 2'd3, 8'h20, 1'b0, 4'b0);
    close_cycle();
    chk(viol == 1'b0 && vmid == 2'd1, "R9 id held", vmid, 1);

    // R6 lock
    drive(1'b1, 2'd0, 8'hF4, 1'b1, 4'b0000);
    chk(s_wr == 1'b0, "R10 lock write not forwarded", s_wr, 0);
    close_cycle();
    chk(locked == 1'b0, "R6 lock bit0=0 no effect", locked, 0);
    drive(1'b1, 2'd0, 8'hF4, 1'b1, 4'b0001);
    close_cycle();
    chk(locked == 1'b1, "R6 lock set", locked, 1);
    chk(viol == 1'b0, "R6 lock write accepted", viol, 0);
    drive(1'b1, 2'd0, 8'hF0, 1'b1, 4'b1111);
    close_cycle();
    chk(men == 4'b0101, "R6 frozen enable", men, 5);
    chk(viol == 1'b1 && vmid == 2'd0, "R6 locked cfg violation", viol, 1);
    drive(1'b1, 2'd0, 8'h30, 1'b0, 4'b0);
    chk(s_wr == 1'b1, "R2 normal write while locked", s_wr, 1);
    close_cycle();

    // R4 reset clears lock
    @(negedge clk); rst_n = 1'b0; #1;
    chk(locked == 1'b0 && men == 4'b1111, "R4 reset clears lock", men, 15);
    @(negedge clk); rst_n = 1'b1;

    // R8 safety-only variant
    drive(1'b1, 2'd2, 8'h10, 1'b0, 4'b0);
    chk(q_wr == 1'b1, "R8 safety master write", q_wr, 1);
    chk(s_wr == 1'b1, "R2 all enabled after reset", s_wr, 1);
    close_cycle();
    drive(1'b1, 2'd0, 8'h10, 1'b0, 4'b0);
    chk(q_wr == 1'b0, "R8 other master blocked", q_wr, 0);
    close_cycle();
    chk(q_viol == 1'b1 && q_vmid == 2'd0, "R8 other master violation", q_viol, 1);
    drive(1'b1, 2'd3, 8'h85, 1'b1, 4'b0);
    chk(q_wr == 1'b0, "R8 other master safety range", q_wr, 0);
    chk(q_rd == 1'b0, "R1 no read on write", q_rd, 0);
    close_cycle();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule